// File: doc/BRIEF.md
# Host-side SMIC message sequencer

This block runs one management request at a time over a byte-wide, three-register device interface: a data register, a control/status register and a flags register. A request carries an address byte, a command byte and up to `PAYLOAD_MAX` payload bytes. The block sends the request one byte at a time. It then reads the reply back, checks that the reply echoes the request, and keeps the reply data bytes in a local buffer. The caller reads that buffer through an index port.

Every byte moves through its own small handshake. The engine writes a phase control code and, for a write, the data byte. It then sets the busy flag with a read-modify-write of the flags register. It polls until the device clears busy, and then compares the status register with the status that this phase expects. If a status is wrong, an echo byte does not match, or a poll times out, the attempt is abandoned and the whole message is started again, up to `MAX_TRIES` attempts. When the request finishes, the block reports success or failure, the completion code, the full reply length and the error byte taken from the last failed status.

Top module: `smic_sequencer`

## Requirements
- R1: After reset and whenever `req_ready` is high, the block makes no device access and `rsp_done` is low. `rsp_done` is a single-cycle pulse issued while `req_ready` is high.
- R2: An attempt writes its first control code (write-start) only after a read of the flags register has shown the busy bit (bit 0) clear.
- R3: A byte transaction always runs in this order: a control code write to select 1, then for writes a data byte write to select 0, then a flags read and a flags write (select 2) that sets bit 0, keeps the other bits and clears the reserved bits 5 and 1, then flags polling until bit 0 is clear, then a status read from select 1.
- R4: The write phase sends the address with write-start. With no payload, the command goes with write-end. Otherwise the command and every payload byte except the last go with write-next, and the last payload byte goes with write-end.
- R5: Write-next and write-end control codes are issued only after the flags register shows transmit-ready (bit 6). Read-start and read-next codes are issued only after it shows receive-ready (bit 7).
- R6: The read-start byte must equal the request address with bit 2 set, and the first read-next byte must equal the request command. A mismatch fails the attempt.
- R7: A read-next from the completion code onward accepts either the next status or the end status, and the byte delivered with the end status is kept as reply data. The end status on the command byte fails the attempt.
- R8: After the end status, the engine issues one read-end code and requires the ready status. Any other status fails the attempt.
- R9: A status mismatch aborts the attempt, and the data register is then read; that byte is reported on `rsp_err`.
- R10: The completion code is reported on `rsp_ccode`. The data bytes that follow it are stored in order at indices 0 up to `REPLY_DEPTH`-1, later bytes are counted but not stored, and `rsp_len` gives the full count.
- R11: A failed attempt restarts the whole message. After `MAX_TRIES` (3) failed attempts, the block finishes with `rsp_ok` low.
- R12: A flags poll that sees `poll_limit` unsatisfied reads in a row fails the attempt, so a stuck device still leads to a finished request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_limit | input | TO_W | Unsatisfied flag reads allowed before a poll fails |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, accepts a request |
| req_addr | input | 8 | Request address byte |
| req_cmd | input | 8 | Request command byte |
| req_len | input | PL_W | Payload byte count, at most PAYLOAD_MAX |
| req_payload | input | PAYLOAD_MAX*8 | Payload, byte i in bits [8i+7:8i] |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_ok | output | 1 | Request succeeded |
| rsp_ccode | output | 8 | Completion code of the reply |
| rsp_len | output | LEN_W | Reply data byte count |
| rsp_err | output | 8 | Data byte read after a status mismatch |
| rsp_idx | input | RI_W | Reply buffer read index |
| rsp_byte | output | 8 | Reply buffer byte at rsp_idx |
| dev_rd | output | 1 | Device register read strobe; data is valid the next cycle |
| dev_wr | output | 1 | Device register write strobe |
| dev_sel | output | 2 | Register select: 0 data, 1 control/status, 2 flags |
| dev_wdata | output | 8 | Device write data |
| dev_rdata | input | 8 | Device read data |

## Verification
The device model in the bench keeps busy set when a request arrives and delays the transmit-ready and receive-ready flags by random amounts. An engine that skips a wait writes a control code while the flag is still low, and the model counts that. Replies range from zero data bytes, where the completion code itself carries the end status, to lengths past the buffer depth. An engine that drops the end byte, or that stops counting at the buffer depth, reports the wrong length or the wrong bytes. Injected faults cover a bad start status on one, two or three attempts, a wrong reply address, a wrong command echo, an early end status, a bad read-end status and a transmit flag that never rises. A wrong retry limit shows up as the wrong attempt count or the wrong outcome, and a missing timeout shows up as a request that never completes.

// File: rtl/smic_sequencer.sv
module smic_sequencer #(
  parameter int PAYLOAD_MAX = 8,
  parameter int REPLY_DEPTH = 8,
  parameter int LEN_W = 8,
  parameter int TO_W = 16,
  parameter int MAX_TRIES = 3,
  parameter int PL_W = $clog2(PAYLOAD_MAX + 1),
  parameter int RI_W = $clog2(REPLY_DEPTH),
  parameter logic [7:0] CC_WR_START = 8'h41,
  parameter logic [7:0] CC_WR_NEXT  = 8'h42,
  parameter logic [7:0] CC_WR_END   = 8'h43,
  parameter logic [7:0] CC_RD_START = 8'h44,
  parameter logic [7:0] CC_RD_NEXT  = 8'h45,
  parameter logic [7:0] CC_RD_END   = 8'h46,
  parameter logic [7:0] SC_READY    = 8'hC0,
  parameter logic [7:0] SC_WR_START = 8'hC1,
  parameter logic [7:0] SC_WR_NEXT  = 8'hC2,
  parameter logic [7:0] SC_WR_END   = 8'hC3,
  parameter logic [7:0] SC_RD_START = 8'hC4,
  parameter logic [7:0] SC_RD_NEXT  = 8'hC5,
  parameter logic [7:0] SC_RD_END   = 8'hC6,
  parameter logic [7:0] FLG_BUSY    = 8'h01,
  parameter logic [7:0] FLG_TX      = 8'h40,
  parameter logic [7:0] FLG_RX      = 8'h80,
  parameter logic [7:0] FLG_RSV     = 8'h22,
  parameter logic [7:0] REPLY_BIT   = 8'h04
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TO_W-1:0]          poll_limit,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [7:0]               req_addr,
  input  logic [7:0]               req_cmd,
  input  logic [PL_W-1:0]          req_len,
  input  logic [PAYLOAD_MAX*8-1:0] req_payload,
  output logic                     rsp_done,
  output logic                     rsp_ok,
  output logic [7:0]               rsp_ccode,
  output logic [LEN_W-1:0]         rsp_len,
  output logic [7:0]               rsp_err,
  input  logic [RI_W-1:0]          rsp_idx,
  output logic [7:0]               rsp_byte,
  output logic                     dev_rd,
  output logic                     dev_wr,
  output logic [1:0]               dev_sel,
  output logic [7:0]               dev_wdata,
  input  logic [7:0]               dev_rdata
);
  localparam int WP_W = $clog2(PAYLOAD_MAX + 2);
  localparam int PI_W = $clog2(PAYLOAD_MAX);
  localparam int TR_W = $clog2(MAX_TRIES + 1);
  localparam logic [1:0] SEL_DATA = 2'd0, SEL_CTL = 2'd1, SEL_FLG = 2'd2;

  typedef enum logic [4:0] {
    S_IDLE, S_ATT, S_PRE, S_PRD, S_PCHK, S_CTL, S_DAT, S_BRD, S_BWR,
    S_NRD, S_NCHK, S_SRD, S_SCHK, S_DRD, S_DCHK, S_ERD, S_ECHK, S_FAIL
  } st_t;
  typedef enum logic [2:0] {OP_WS, OP_WN, OP_WE, OP_RS, OP_RN, OP_RE} op_t;

  st_t             state;
  op_t             op;
  logic [7:0]      addr_q, cmd_q;
  logic [PL_W-1:0] len_q;
  logic [7:0]      pay_q [PAYLOAD_MAX];
  logic [7:0]      rbuf  [REPLY_DEPTH];
  logic [WP_W-1:0] wpos;
  logic [1:0]      rpos;
  logic            rdph, saw_end, ending;
  logic [TR_W-1:0] tries;
  logic [TO_W-1:0] pcnt;
  logic [LEN_W-1:0] rcnt;
  logic [7:0]      ccode_q, err_q, ctl_code, wbyte;
  logic            pre_ok, st_ok, tmo, busy_clr;
  logic [PI_W-1:0] pidx;

  assign pidx     = PI_W'(wpos - WP_W'(2));
  assign wbyte    = (wpos == '0) ? addr_q : (wpos == WP_W'(1)) ? cmd_q : pay_q[pidx];
  assign busy_clr = (dev_rdata & FLG_BUSY) == 8'h00;
  assign tmo      = ((TO_W+1)'(pcnt) + (TO_W+1)'(1)) >= (TO_W+1)'(poll_limit);

  always_comb begin
    if (!rdph) op = (wpos == '0) ? OP_WS :
                    (wpos == WP_W'(len_q) + WP_W'(1)) ? OP_WE : OP_WN;
    else if (ending) op = OP_RE;
    else op = (rpos == 2'd0) ? OP_RS : OP_RN;
  end

  always_comb begin
    ctl_code = CC_RD_END;
    pre_ok   = 1'b1;
    st_ok    = dev_rdata == SC_READY;
    case (op)
      OP_WS: begin ctl_code = CC_WR_START; pre_ok = busy_clr; st_ok = dev_rdata == SC_WR_START; end
      OP_WN: begin ctl_code = CC_WR_NEXT; pre_ok = (dev_rdata & FLG_TX) != 0; st_ok = dev_rdata == SC_WR_NEXT; end
      OP_WE: begin ctl_code = CC_WR_END; pre_ok = (dev_rdata & FLG_TX) != 0; st_ok = dev_rdata == SC_WR_END; end
      OP_RS: begin
        ctl_code = CC_RD_START;
        pre_ok   = busy_clr && ((dev_rdata & FLG_RX) != 0);
        st_ok    = dev_rdata == SC_RD_START;
      end
      OP_RN: begin
        ctl_code = CC_RD_NEXT;
        pre_ok   = (dev_rdata & FLG_RX) != 0;
        st_ok    = (dev_rdata == SC_RD_NEXT) || (rpos != 2'd1 && dev_rdata == SC_RD_END);
      end
      default: ;
    endcase
  end

  assign req_ready = state == S_IDLE;
  assign dev_rd    = state inside {S_PRD, S_BRD, S_NRD, S_SRD, S_DRD, S_ERD};
  assign dev_wr    = state inside {S_CTL, S_DAT, S_BWR};
  assign dev_sel   = (state inside {S_CTL, S_SRD}) ? SEL_CTL :
                     (state inside {S_DAT, S_DRD, S_ERD}) ? SEL_DATA : SEL_FLG;
  assign dev_wdata = (state == S_CTL) ? ctl_code :
                     (state == S_DAT) ? wbyte :
                     (state == S_BWR) ? ((dev_rdata | FLG_BUSY) & ~FLG_RSV) : 8'h00;
  assign rsp_ccode = ccode_q;
  assign rsp_len   = rcnt;
  assign rsp_err   = err_q;
  assign rsp_byte  = rbuf[rsp_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; rsp_done <= 1'b0; rsp_ok <= 1'b0;
      addr_q <= '0; cmd_q <= '0; len_q <= '0; wpos <= '0; rpos <= '0;
      rdph <= 1'b0; saw_end <= 1'b0; ending <= 1'b0; tries <= '0; pcnt <= '0;
      rcnt <= '0; ccode_q <= '0; err_q <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr; cmd_q <= req_cmd; len_q <= req_len;
          for (int i = 0; i < PAYLOAD_MAX; i++) pay_q[i] <= req_payload[i*8 +: 8];
          tries <= '0; err_q <= '0;
          state <= S_ATT;
        end
        S_ATT: begin
          rdph <= 1'b0; wpos <= '0; rpos <= '0; saw_end <= 1'b0; ending <= 1'b0;
          rcnt <= '0; ccode_q <= '0; tries <= tries + TR_W'(1);
          state <= S_PRE;
        end
        S_PRE: begin
          pcnt  <= '0;
          state <= (op == OP_RE) ? S_CTL : S_PRD;
        end
        S_PRD: state <= S_PCHK;
        S_PCHK:
          if (pre_ok) state <= S_CTL;
          else if (tmo) state <= S_FAIL;
          else begin pcnt <= pcnt + TO_W'(1); state <= S_PRD; end
        S_CTL: state <= rdph ? S_BRD : S_DAT;
        S_DAT: state <= S_BRD;
        S_BRD: state <= S_BWR;
        S_BWR: begin pcnt <= '0; state <= S_NRD; end
        S_NRD: state <= S_NCHK;
        S_NCHK:
          if (busy_clr) state <= S_SRD;
          else if (tmo) state <= S_FAIL;
          else begin pcnt <= pcnt + TO_W'(1); state <= S_NRD; end
        S_SRD: state <= S_SCHK;
        S_SCHK:
          if (!st_ok) state <= S_ERD;
          else if (op == OP_RE) begin
            rsp_ok <= 1'b1; rsp_done <= 1'b1; state <= S_IDLE;
          end else if (!rdph) begin
            if (op == OP_WE) rdph <= 1'b1;
            wpos  <= wpos + WP_W'(1);
            state <= S_PRE;
          end else begin
            saw_end <= dev_rdata == SC_RD_END;
            state   <= S_DRD;
          end
        S_DRD: state <= S_DCHK;
        S_DCHK: begin
          state <= S_PRE;
          case (rpos)
            2'd0: if (dev_rdata != (addr_q | REPLY_BIT)) state <= S_FAIL;
            2'd1: if (dev_rdata != cmd_q) state <= S_FAIL;
            2'd2: ccode_q <= dev_rdata;
            default: begin
              if (rcnt < LEN_W'(REPLY_DEPTH)) rbuf[RI_W'(rcnt)] <= dev_rdata;
              rcnt <= rcnt + LEN_W'(1);
            end
          endcase
          if (rpos != 2'd3) rpos <= rpos + 2'd1;
          if (saw_end) ending <= 1'b1;
        end
        S_ERD: state <= S_ECHK;
        S_ECHK: begin err_q <= dev_rdata; state <= S_FAIL; end
        S_FAIL:
          if (tries == TR_W'(MAX_TRIES)) begin
            rsp_ok <= 1'b0; rsp_done <= 1'b1; state <= S_IDLE;
          end else state <= S_ATT;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smic_sequencer_chk.sv
module smic_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       rsp_done,
  input logic       dev_rd,
  input logic       dev_wr,
  input logic [1:0] dev_sel
);
  assert_data_after_ctl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr && dev_sel == 2'd0) |-> $past(dev_wr && dev_sel == 2'd1));

  assert_busy_rmw_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr && dev_sel == 2'd2) |-> $past(dev_rd && dev_sel == 2'd2));

  assert_status_after_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rd && dev_sel == 2'd1) |-> $past(dev_rd && dev_sel == 2'd2, 2));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!dev_rd && !dev_wr));

  assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
endmodule

bind smic_sequencer smic_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done),
  .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_sel(dev_sel)
);

// File: tb/test_smic_sequencer.sv
`timescale 1ns/1ps
module test_smic_sequencer;
  localparam int PM = 8, RD = 8, LW = 8, TW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [TW-1:0] poll_limit = 16'd200;
  logic req_valid = 1'b0, req_ready;
  logic [7:0] req_addr = '0, req_cmd = '0;
  logic [3:0] req_len = '0;
  logic [PM*8-1:0] req_payload = '0;
  logic rsp_done, rsp_ok;
  logic [7:0] rsp_ccode, rsp_err, rsp_byte;
  logic [LW-1:0] rsp_len;
  logic [2:0] rsp_idx = '0;
  logic dev_rd, dev_wr;
  logic [1:0] dev_sel;
  logic [7:0] dev_wdata, dev_rdata;

  smic_sequencer i_smic_sequencer (
    .clk(clk), .rst_n(rst_n), .poll_limit(poll_limit),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_cmd(req_cmd),
    .req_len(req_len), .req_payload(req_payload), .rsp_done(rsp_done), .rsp_ok(rsp_ok),
    .rsp_ccode(rsp_ccode), .rsp_len(rsp_len), .rsp_err(rsp_err), .rsp_idx(rsp_idx),
    .rsp_byte(rsp_byte), .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_sel(dev_sel),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;

  // fault and reply configuration, written only while the engine is idle
  int fail_n = 0, pre_busy = 0, rlen = 3;
  bit addr_bad = 0, cmd_bad = 0, early_end = 0, bad_end = 0, tx_hang = 0;
  logic [7:0] rb [16];

  // device model state
  logic m_busy, tx_flag, rx_flag, rx_av;
  logic [7:0] m_sts, m_dout, m_din, m_ctl;
  int bcnt, txw, rxw, wn, rp, att, nexts, ends, rde, viol, rmw_bad;
  logic [7:0] wb [10];
  logic [7:0] flags_val;
  assign flags_val = {rx_flag, tx_flag, 1'b1, 2'b00, 1'b1, 1'b1, m_busy};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; tx_flag <= 0; rx_flag <= 0; rx_av <= 0; m_sts <= 8'hC0;
      m_dout <= 0; m_din <= 0; m_ctl <= 0; bcnt <= 0; txw <= 0; rxw <= 0;
      wn <= 0; rp <= 0; att <= 0; nexts <= 0; ends <= 0; rde <= 0;
      viol <= 0; rmw_bad <= 0; dev_rdata <= 0;
    end else begin
      if (dev_rd) dev_rdata <= (dev_sel == 2'd0) ? m_dout : (dev_sel == 2'd1) ? m_sts : flags_val;
      if (!m_busy) begin
        if (txw != 0) txw <= txw - 1; else if (!tx_hang) tx_flag <= 1;
        if (rxw != 0) rxw <= rxw - 1; else rx_flag <= rx_av;
      end
      if (req_valid && req_ready) begin
        att <= 0; m_ctl <= 8'h00; rx_av <= 0; rx_flag <= 0;
        if (pre_busy != 0) begin m_busy <= 1; bcnt <= pre_busy; end
      end
      if (dev_wr) begin
        if (dev_sel == 2'd0) m_din <= dev_wdata;
        else if (dev_sel == 2'd1) begin
          m_ctl <= dev_wdata;
          if (dev_wdata == 8'h41 && m_busy) viol <= viol + 1;                      // R2
          if ((dev_wdata == 8'h42 || dev_wdata == 8'h43) && !tx_flag) viol <= viol + 1; // R5
          if ((dev_wdata == 8'h44 || dev_wdata == 8'h45) && !rx_flag) viol <= viol + 1; // R5
        end else begin
          if (!(dev_wdata[0] && !dev_wdata[5] && !dev_wdata[1] && dev_wdata[2])) rmw_bad <= rmw_bad + 1;
          if (dev_wdata[0]) begin m_busy <= 1; bcnt <= $urandom % 4; end
        end
      end else if (m_busy) begin
        if (bcnt != 0) bcnt <= bcnt - 1;
        else begin
          m_busy <= 0;
          tx_flag <= 0; txw <= $urandom % 3; rx_flag <= 0; rxw <= $urandom % 3;
          case (m_ctl)
            8'h41: begin
              att <= att + 1; rx_av <= 0;
              if (att < fail_n) begin m_sts <= 8'hC0; m_dout <= 8'h8A; end
              else begin m_sts <= 8'hC1; wb[0] <= m_din; wn <= 1; nexts <= 0; ends <= 0; rde <= 0; end
            end
            8'h42: begin if (wn < 10) wb[wn] <= m_din; wn <= wn + 1; nexts <= nexts + 1; m_sts <= 8'hC2; end
            8'h43: begin if (wn < 10) wb[wn] <= m_din; wn <= wn + 1; ends <= ends + 1; m_sts <= 8'hC3; rx_av <= 1; rp <= 0; end
            8'h44: begin m_dout <= rb[0]; m_sts <= 8'hC4; rp <= 1; end
            8'h45: begin
              m_dout <= rb[rp];
              m_sts <= (rp == rlen - 1 || (early_end && rp == 1)) ? 8'hC6 : 8'hC5;
              rp <= rp + 1;
            end
            8'h46: begin
              rde <= rde + 1; rx_av <= 0;
              if (bad_end) begin m_sts <= 8'hC9; m_dout <= 8'h5B; end else m_sts <= 8'hC0;
            end
            default: ;
          endcase
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_ok();
    return fail_n < 3 && !addr_bad && !cmd_bad && !early_end && !bad_end && !tx_hang;
  endfunction

  function automatic int exp_err(input logic [7:0] cmd);
    if (fail_n >= 3) return 8'h8A;
    if (early_end) return cmd;
    if (bad_end && !addr_bad && !cmd_bad) return 8'h5B;
    return 0;
  endfunction

  task automatic run(input string tag, input logic [7:0] a, input logic [7:0] c,
                     input int len, input int n, input logic [7:0] cc);
    logic [7:0] pay [PM];
    int wd;
    bit ok;
    for (int i = 0; i < PM; i++) pay[i] = $urandom;
    rb[0] = addr_bad ? (a | 8'h04) ^ 8'h10 : (a | 8'h04);
    rb[1] = cmd_bad ? c ^ 8'h01 : c;
    rb[2] = cc;
    for (int i = 0; i < 13; i++) rb[3 + i] = $urandom;
    rlen = 3 + n;
    @(negedge clk);
    req_addr = a; req_cmd = c; req_len = 4'(len);
    for (int i = 0; i < PM; i++) req_payload[i*8 +: 8] = pay[i];
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    wd = 0;
    while (!rsp_done && wd < 20000) begin @(negedge clk); wd++; end
    if (!rsp_done) begin
      chk({tag, " R12 watchdog"}, 0, 1);
      return;
    end
    ok = exp_ok();
    chk({tag, " R11 outcome"}, rsp_ok, ok);
    chk({tag, " R11 attempts"}, att, ok ? fail_n + 1 : 3);
    chk({tag, " R2/R5 ready waits"}, viol, 0);
    chk({tag, " R3 busy rmw"}, rmw_bad, 0);
    if (ok) begin
      chk({tag, " R10 ccode"}, rsp_ccode, cc);
      chk({tag, " R10 length"}, rsp_len, n);
      for (int i = 0; i < n && i < RD; i++) begin
        rsp_idx = 3'(i); #1;
        chk({tag, " R10 reply byte"}, rsp_byte, rb[3 + i]);
      end
      chk({tag, " R4 write count"}, wn, len + 2);
      chk({tag, " R4 address"}, wb[0], a);
      chk({tag, " R4 command"}, wb[1], c);
      for (int i = 0; i < len; i++) chk({tag, " R4 payload"}, wb[2 + i], pay[i]);
      chk({tag, " R4 write-next count"}, nexts, len);
      chk({tag, " R4 write-end count"}, ends, 1);
      chk({tag, " R8 read-end count"}, rde, 1);
    end else
      chk({tag, " R9 error byte"}, rsp_err, exp_err(c));
  endtask

  task automatic clear_faults();
    fail_n = 0; addr_bad = 0; cmd_bad = 0; early_end = 0; bad_end = 0; tx_hang = 0; pre_busy = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset ready", req_ready, 1);
    chk("R1 reset done", rsp_done, 0);
    chk("R1 reset quiet", {dev_rd, dev_wr}, 0);

    clear_faults();
    pre_busy = 12; run("R2 busy at start, no payload", 8'h18, 8'h01, 0, 4, 8'h00);
    pre_busy = 0;  run("R4 full payload", 8'h2C, 8'h22, PM, 2, 8'h00);
    run("R7 empty reply", 8'h06, 8'h09, 1, 0, 8'hC1);
    run("R10 reply at depth", 8'h30, 8'h40, 3, RD, 8'h00);
    run("R10 reply past depth", 8'h34, 8'h41, 2, 12, 8'h00);
    fail_n = 1; run("R11 one retry", 8'h18, 8'h02, 2, 3, 8'h00);
    fail_n = 2; run("R11 two retries", 8'h18, 8'h03, 0, 1, 8'h00);
    fail_n = 3; run("R9 R11 all attempts fail", 8'h18, 8'h04, 1, 1, 8'h00);
    clear_faults(); addr_bad = 1; run("R6 address mismatch", 8'h18, 8'h05, 1, 2, 8'h00);
    clear_faults(); cmd_bad = 1; run("R6 command mismatch", 8'h1C, 8'h06, 0, 2, 8'h00);
    clear_faults(); early_end = 1; run("R7 end on command byte", 8'h18, 8'h07, 0, 3, 8'h00);
    clear_faults(); bad_end = 1; run("R8 bad read-end status", 8'h18, 8'h08, 1, 1, 8'h00);
    clear_faults(); tx_hang = 1; poll_limit = 16'd16;
    run("R12 transmit never ready", 8'h18, 8'h09, 2, 1, 8'h00);
    clear_faults(); poll_limit = 16'd200;

    for (int t = 0; t < 24; t++) begin
      clear_faults();
      if ($urandom % 4 == 0) fail_n = 1 + $urandom % 2;
      pre_busy = $urandom % 6;
      run("R4 R10 random", 8'($urandom), 8'($urandom), $urandom % (PM + 1), $urandom % 13, 8'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule